// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind a two-wire serial bus transaction controller and in front of a non-volatile byte array. When the controller opens a write transaction it hands over an 11-bit byte address. Each data byte that follows is placed into a 16-byte page buffer, at a lane offset that advances with every byte. When the bus STOP is seen and at least one lane holds new data, the whole page is handed to the array in a single strobe, together with a per-lane mask. The block then reports busy for a fixed number of system clocks, which stand in for the programming time of the cells. While busy, the block ignores every input.

One address is special: when all address bits are one, data bytes never enter the buffer. Each one loads its low seven bits straight into a volatile position register on the cycle it completes. A STOP after such bytes starts no programming cycle. A repeated START or a write-protect condition reaches the block as an abort pulse, which throws the pending page away.

Top module: `page_commit_seq`

## Requirements
- R1: After reset `busy` and `mem_we` are low and `wiper` holds mid-scale, 64.
- R2: The upper 7 bits of `wr_addr` select the page and are presented on `mem_page`. The low 4 bits give the starting lane. Lane i of `mem_data` is bits [8i+7:8i], and its enable is bit i of `mem_mask`.
- R3: Each accepted data byte advances the lane offset by one. After lane 15 the offset wraps to lane 0 of the same page, and the page never changes within a transaction.
- R4: `mem_mask` has a bit set only for lanes written in the transaction. A lane written twice carries the later byte.
- R5: A commit starts only on `stop_det`. In the cycle after `stop_det` is sampled, `mem_we` is high for exactly one cycle and `busy` rises in that same cycle.
- R6: `busy` stays high for exactly WR_CYCLES clock cycles and then falls.
- R7: While `busy` is high, `wr_begin`, `byte_done`, `stop_det` and `xfer_abort` have no effect. They change neither `wiper` nor any later commit.
- R8: A STOP with no data byte in the transaction starts no commit, and `busy` stays low.
- R9: For the all-ones address 0x7FF, each data byte loads `byte_data[6:0]` into `wiper`, visible one cycle after `byte_done`. Such bytes are not buffered, and the STOP that follows starts no commit.
- R10: `xfer_abort` discards the transaction, including any byte given in the same cycle, whether buffered or volatile. A later STOP then starts no commit.
- R11: A data byte and `stop_det` in the same cycle commit together, with that byte included in the page.
- R12: Outside a transaction, `byte_done` and `stop_det` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_begin | input | 1 | Pulse: a write transaction opens with `wr_addr` |
| wr_addr | input | 11 | Byte address of the first data byte |
| byte_done | input | 1 | Pulse on the SCL fall that shifts in a data byte's LSB |
| byte_data | input | 8 | The completed data byte |
| stop_det | input | 1 | Pulse on a bus STOP condition |
| xfer_abort | input | 1 | Pulse: repeated START or write protect ends the transaction |
| mem_we | output | 1 | One-cycle page write strobe to the array |
| mem_page | output | 7 | Page number being written |
| mem_data | output | 128 | Page contents, 16 lanes of 8 bits |
| mem_mask | output | 16 | Lane enables for the page write |
| busy | output | 1 | Programming cycle in progress, inputs ignored |
| wiper | output | 7 | Volatile position register |

## Verification
The last data byte of a transaction and the STOP can land in the same clock. The byte must then still be part of the committed page rather than being lost to the commit. The bench drives both pulses together in one cycle and checks that the captured mask and lane contents include that byte. A second collision pairs a data byte with the abort pulse, once for a buffered address and once for the volatile one. Here the abort must win: no commit follows, and the position register keeps its earlier value.

// File: rtl/page_commit_seq.sv
module page_commit_seq #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int POS_W      = 7,
  parameter int WR_CYCLES  = 2000,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W,
  localparam int BUF_W     = PAGE_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_det,
  input  logic              xfer_abort,
  output logic              mem_we,
  output logic [PAGE_W-1:0] mem_page,
  output logic [BUF_W-1:0]  mem_data,
  output logic [PAGE_BYTES-1:0] mem_mask,
  output logic              busy,
  output logic [POS_W-1:0]  wiper
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_PROG} state_t;

  state_t               state_q;
  logic [PAGE_W-1:0]    page_q;
  logic [OFF_W-1:0]     off_q;
  logic                 vol_q;
  logic [PAGE_BYTES-1:0] dirty_q, mask_q, lane_sel, dirty_nx;
  logic [BUF_W-1:0]     buf_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 we_q;
  logic [POS_W-1:0]     wiper_q;
  logic                 take;

  assign take     = (state_q == ST_FILL) && byte_done && !xfer_abort;
  assign lane_sel = (take && !vol_q) ? ({{(PAGE_BYTES-1){1'b0}}, 1'b1} << off_q) : '0;
  assign dirty_nx = dirty_q | lane_sel;

  assign mem_we   = we_q;
  assign mem_page = page_q;
  assign mem_data = buf_q;
  assign mem_mask = mask_q;
  assign busy     = (state_q == ST_PROG);
  assign wiper    = wiper_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      vol_q   <= 1'b0;
      dirty_q <= '0;
      mask_q  <= '0;
      buf_q   <= '0;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      wiper_q <= POS_W'(1 << (POS_W - 1));
    end else begin
      we_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (wr_begin) begin
          page_q  <= wr_addr[ADDR_W-1:OFF_W];
          off_q   <= wr_addr[OFF_W-1:0];
          vol_q   <= &wr_addr;
          dirty_q <= '0;
          state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (xfer_abort) begin
            dirty_q <= '0;
            state_q <= ST_IDLE;
          end else begin
            if (take) begin
              if (vol_q) begin
                wiper_q <= byte_data[POS_W-1:0];
              end else begin
                buf_q[off_q*DATA_W +: DATA_W] <= byte_data;
                off_q <= off_q + 1'b1;
              end
            end
            dirty_q <= dirty_nx;
            if (stop_det) begin
              if (|dirty_nx) begin
                mask_q  <= dirty_nx;
                we_q    <= 1'b1;
                cnt_q   <= CNT_W'(WR_CYCLES - 1);
                state_q <= ST_PROG;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
        end
        ST_PROG: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

module page_commit_seq_chk #(
  parameter int WR_CYCLES = 2000,
  parameter int PAGE_W    = 7,
  parameter int BUF_W     = 128,
  parameter int LANES     = 16,
  parameter int POS_W     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [PAGE_W-1:0] mem_page,
  input logic [BUF_W-1:0]  mem_data,
  input logic [LANES-1:0]  mem_mask,
  input logic              busy,
  input logic [POS_W-1:0]  wiper
);
  logic [31:0] bc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bc <= '0;
    else if (busy) bc <= bc + 1;
    else           bc <= '0;
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bc < 32'(WR_CYCLES)));

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bc) == 32'(WR_CYCLES - 1)));

  // R5
  we_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $rose(busy));

  // R5
  we_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_we);

  // R4
  we_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_mask != '0));

  // R7
  wiper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(wiper));

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_we) |-> ($stable(mem_page) && $stable(mem_data) && $stable(mem_mask)));
endmodule

bind page_commit_seq page_commit_seq_chk #(
  .WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W), .BUF_W(BUF_W), .LANES(PAGE_BYTES), .POS_W(POS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_page(mem_page), .mem_data(mem_data),
  .mem_mask(mem_mask), .busy(busy), .wiper(wiper)
);

// File: tb/page_commit_seq_test.sv
module page_commit_seq_test;
  localparam int WRC = 40;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_begin = 1'b0;
  logic [10:0]  wr_addr = '0;
  logic         byte_done = 1'b0;
  logic [7:0]   byte_data = '0;
  logic         stop_det = 1'b0;
  logic         xfer_abort = 1'b0;
  logic         mem_we;
  logic [6:0]   mem_page;
  logic [127:0] mem_data;
  logic [15:0]  mem_mask;
  logic         busy;
  logic [6:0]   wiper;

  page_commit_seq #(.WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_addr(wr_addr),
    .byte_done(byte_done), .byte_data(byte_data), .stop_det(stop_det),
    .xfer_abort(xfer_abort), .mem_we(mem_we), .mem_page(mem_page),
    .mem_data(mem_data), .mem_mask(mem_mask), .busy(busy), .wiper(wiper)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int errors = 0;
  int n_commit = 0;
  int run = 0;
  int last_len = 0;
  logic [6:0]   cap_page;
  logic [15:0]  cap_mask;
  logic [127:0] cap_data;

  logic [7:0]  m_lane [16];
  logic [15:0] m_mask;
  logic [3:0]  m_off;
  logic [6:0]  m_page;

  always @(negedge clk) begin
    if (mem_we) begin
      n_commit++;
      cap_page = mem_page;
      cap_mask = mem_mask;
      cap_data = mem_data;
    end
    if (busy) run++;
    else if (run != 0) begin
      last_len = run;
      run = 0;
    end
  end

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_open(input logic [10:0] a);
    m_page = a[10:4];
    m_off  = a[3:0];
    m_mask = '0;
  endtask

  task automatic m_put(input logic [7:0] d);
    m_lane[m_off] = d;
    m_mask[m_off] = 1'b1;
    m_off = m_off + 1'b1;
  endtask

  task automatic p_begin(input logic [10:0] a);
    wr_begin = 1'b1; wr_addr = a;
    @(negedge clk);
    wr_begin = 1'b0;
  endtask

  task automatic p_byte(input logic [7:0] d, input logic stp, input logic abt);
    byte_done = 1'b1; byte_data = d; stop_det = stp; xfer_abort = abt;
    @(negedge clk);
    byte_done = 1'b0; stop_det = 1'b0; xfer_abort = 1'b0;
  endtask

  task automatic p_stop();
    stop_det = 1'b1;
    @(negedge clk);
    stop_det = 1'b0;
  endtask

  task automatic p_abort();
    xfer_abort = 1'b1;
    @(negedge clk);
    xfer_abort = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_commit(input string tag);
    check(cap_page, m_page, {tag, " page"});
    check(cap_mask, m_mask, {tag, " mask"});
    for (int i = 0; i < 16; i++)
      if (m_mask[i]) check(cap_data[i*8 +: 8], m_lane[i], {tag, " lane"});
  endtask

  task automatic t_reset();
    check(busy, 1'b0, "R1 busy");
    check(mem_we, 1'b0, "R1 mem_we");
    check(wiper, 7'd64, "R1 wiper");
  endtask

  task automatic t_full_page();
    int n0 = n_commit;
    m_open(11'h230);
    p_begin(11'h230);
    for (int i = 0; i < 16; i++) begin
      m_put(8'hA0 + 8'(i));
      p_byte(8'hA0 + 8'(i), 1'b0, 1'b0);
    end
    repeat (3) @(negedge clk);
    check(n_commit, n0, "R5 no commit before stop");
    p_stop();
    check(mem_we, 1'b1, "R5 strobe after stop");
    check(busy, 1'b1, "R5 busy after stop");
    @(negedge clk);
    check(mem_we, 1'b0, "R5 strobe one cycle");
    wait_idle();
    check(n_commit, n0 + 1, "R5 single commit");
    check(last_len, WRC, "R6 busy length");
    check_commit("R2 full page");
  endtask

  task automatic t_wrap();
    m_open(11'h1FE);
    p_begin(11'h1FE);
    m_put(8'h11); p_byte(8'h11, 1'b0, 1'b0);
    m_put(8'h22); p_byte(8'h22, 1'b0, 1'b0);
    m_put(8'h33); p_byte(8'h33, 1'b0, 1'b0);
    p_stop();
    wait_idle();
    check(cap_mask, 16'hC001, "R3 wrap mask");
    check_commit("R3 wrap");
  endtask

  task automatic t_top_lane();
    m_open(11'h05F);
    p_begin(11'h05F);
    m_put(8'h77); p_byte(8'h77, 1'b0, 1'b0);
    p_stop();
    wait_idle();
    check(cap_mask, 16'h8000, "R2 top lane mask");
    check_commit("R2 top lane");
  endtask

  task automatic t_overwrite();
    m_open(11'h100);
    p_begin(11'h100);
    for (int i = 0; i < 17; i++) begin
      m_put(8'h40 + 8'(i));
      p_byte(8'h40 + 8'(i), 1'b0, 1'b0);
    end
    p_stop();
    wait_idle();
    check(cap_data[7:0], 8'h50, "R4 later byte wins");
    check_commit("R4 overwrite");
  endtask

  task automatic t_empty();
    int n0 = n_commit;
    p_begin(11'h300);
    p_stop();
    check(busy, 1'b0, "R8 no busy");
    wait_idle();
    check(n_commit, n0, "R8 no commit");
  endtask

  task automatic t_volatile();
    int n0 = n_commit;
    p_begin(11'h7FF);
    p_byte(8'hD5, 1'b0, 1'b0);
    check(wiper, 7'h55, "R9 wiper first");
    p_byte(8'h12, 1'b0, 1'b0);
    check(wiper, 7'h12, "R9 wiper second");
    p_stop();
    check(busy, 1'b0, "R9 no busy");
    wait_idle();
    check(n_commit, n0, "R9 no commit");
  endtask

  task automatic t_abort();
    int n0 = n_commit;
    p_begin(11'h040);
    p_byte(8'h01, 1'b0, 1'b0);
    p_byte(8'h02, 1'b0, 1'b0);
    p_abort();
    p_stop();
    wait_idle();
    check(n_commit, n0, "R10 abort no commit");
    p_begin(11'h7FF);
    p_byte(8'h2B, 1'b0, 1'b1);
    check(wiper, 7'h12, "R10 abort drops volatile byte");
    p_begin(11'h060);
    p_byte(8'h09, 1'b0, 1'b1);
    p_stop();
    wait_idle();
    check(n_commit, n0, "R10 abort with byte no commit");
  endtask

  task automatic t_byte_stop();
    m_open(11'h080);
    p_begin(11'h080);
    m_put(8'h11); p_byte(8'h11, 1'b0, 1'b0);
    m_put(8'h22); p_byte(8'h22, 1'b1, 1'b0);
    check(mem_we, 1'b1, "R11 strobe with last byte");
    wait_idle();
    check(cap_mask, 16'h0003, "R11 mask includes last byte");
    check_commit("R11 byte with stop");
  endtask

  task automatic t_busy_ignore();
    int n0 = n_commit;
    p_begin(11'h010);
    p_byte(8'h99, 1'b0, 1'b0);
    p_stop();
    p_begin(11'h7FF);
    p_byte(8'h3C, 1'b0, 1'b0);
    p_stop();
    p_abort();
    wait_idle();
    check(wiper, 7'h12, "R7 wiper untouched while busy");
    check(n_commit, n0 + 1, "R7 no extra commit");
    m_open(11'h020);
    p_begin(11'h020);
    m_put(8'h44); p_byte(8'h44, 1'b0, 1'b0);
    p_stop();
    wait_idle();
    check(n_commit, n0 + 2, "R7 next transaction commits");
    check_commit("R7 next transaction");
  endtask

  task automatic t_idle_ignore();
    int n0 = n_commit;
    p_byte(8'h5A, 1'b0, 1'b0);
    p_stop();
    wait_idle();
    check(n_commit, n0, "R12 idle no commit");
    check(wiper, 7'h12, "R12 idle wiper");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_page();
    t_wrap();
    t_top_lane();
    t_overwrite();
    t_empty();
    t_volatile();
    t_abort();
    t_byte_stop();
    t_busy_ignore();
    t_idle_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule